// File: doc/BRIEF.md
# Serial Command Front-End for a Dual-Channel Wiper Device

This block is the serial slave side of a device with two channels, each holding a wiper position and four stored data registers. It receives SCK, SI, an active-low chip select and an active-low pause input. All four are brought into the system clock domain, and their edges are found from the synchronized copies. Each transaction opens when chip select falls. It begins with an identification byte, which must carry a fixed device-type code and match two strap pins. An instruction byte follows. It holds an opcode, a register pointer and a channel pointer.

Once the instruction is decoded, the block issues single-cycle command strobes to a register bank. Write commands take a third byte from SI. Read commands shift a third byte out on SO, using data the bank returns. Transfer commands finish after the instruction byte. The open-ended stepping command turns every following SCK pulse into an up or down step strobe for the selected wiper. The pause input freezes the bit sequence in place and releases SO, so a transaction can resume later at the same bit.

Top module: `spi_cmd_front`

## Requirements
- R1: After reset, no command is accepted until chip select has been seen high and then falls. While chip select is high, `so_oe_o` is 0.
- R2: The first byte, sent MSB first, must be `0101`, then `00`, then the level of `dev_addr_i[1]` and then `dev_addr_i[0]`. On any mismatch the rest of the transaction produces no strobe.
- R3: The second byte carries the opcode in bits 7:4, the register select in bits 3:2, a zero in bit 1 and the channel in bit 0. Opcode codes are: 1001 read wiper, 1010 write wiper, 1011 read register, 1100 write register, 1101 load one wiper from a register, 1110 save one wiper to a register, 0001 load both wipers, 1000 save both wipers, 0010 step, 0101 read status. Any other code makes the transaction produce no strobe.
- R4: For write wiper and write register, the third byte on SI is two pad bits followed by D5..D0, MSB first. After its last bit, one `cmd_valid_o` pulse of a single cycle carries the opcode, channel, select and data.
- R5: For read wiper, read register and read status, `cmd_valid_o` pulses after the instruction byte. During the third byte, SO is enabled and presents two zero bits followed by the 6-bit `rd_data_i` that the bank returns for the command outputs, MSB first. SO changes only after a falling SCK edge.
- R6: Read status returns seven zero bits followed by the level of `wip_i`.
- R7: The four transfer opcodes pulse `cmd_valid_o` after the instruction byte. The two global ones report channel 0 whatever bit 0 carried.
- R8: After the step opcode, every further rising SCK gives one `step_valid_o` pulse on the channel in `cmd_chan_o`. `step_up_o` is 1 when SI was 1 and 0 when SI was 0. A step pulse never coincides with a command pulse.
- R9: If chip select rises before the byte that completes a command, that transaction issues no strobe. Strobes never occur while chip select stays high.
- R10: Pause low while SCK is low freezes the sequence, disables SO and ignores SCK edges. Pause high while SCK is low resumes the sequence at the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock (asynchronous) |
| si_i | input | 1 | Serial data in |
| csn_i | input | 1 | Chip select, active low |
| holdn_i | input | 1 | Pause, active low |
| dev_addr_i | input | 2 | Strap address pins |
| wip_i | input | 1 | Write-in-progress flag from the bank |
| rd_data_i | input | DATA_W | Read value returned for the current command outputs |
| so_o | output | 1 | Serial data out (0 when disabled) |
| so_oe_o | output | 1 | Output enable for SO |
| cmd_valid_o | output | 1 | Single-cycle command strobe |
| cmd_op_o | output | 4 | Opcode of the current command |
| cmd_chan_o | output | 1 | Channel pointer |
| cmd_sel_o | output | 2 | Register pointer |
| cmd_data_o | output | DATA_W | Write data |
| step_valid_o | output | 1 | Single-cycle wiper step strobe |
| step_up_o | output | 1 | Step direction, 1 is up |

## Verification
A sequencer state that is wrong usually shows up as a missing, extra or misplaced strobe. This appears within one system clock of the SCK edge that ends the affected byte, so the scoreboard finds it when the transaction ends. A shift register or bit counter that slips by one bit shows up on the next completed byte, as wrong write data or a wrong SO bit during a read. The pause and abort cases target state that should be frozen or dropped: a fault there appears in the first byte after the resume, or in the first strobe the next transaction issues.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [3:0] DEV_TYPE = 4'b0101;

    typedef enum logic [3:0] {
        OP_LOAD_ALL = 4'b0001,
        OP_STEP     = 4'b0010,
        OP_STATUS   = 4'b0101,
        OP_SAVE_ALL = 4'b1000,
        OP_RD_WIPER = 4'b1001,
        OP_WR_WIPER = 4'b1010,
        OP_RD_REG   = 4'b1011,
        OP_WR_REG   = 4'b1100,
        OP_LOAD_ONE = 4'b1101,
        OP_SAVE_ONE = 4'b1110
    } op_e;

    typedef enum logic [2:0] {
        CLS_BAD,
        CLS_WRITE,
        CLS_READ,
        CLS_XFER,
        CLS_STEP
    } cls_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ID,
        ST_INSTR,
        ST_DATA_IN,
        ST_DATA_OUT,
        ST_STEP,
        ST_DONE
    } seq_e;

    typedef struct packed {
        op_e        op;
        logic       chan;
        logic [1:0] sel;
    } cmd_t;

    function automatic cls_e classify(input logic [3:0] code);
        case (code)
            OP_WR_WIPER, OP_WR_REG:                        return CLS_WRITE;
            OP_RD_WIPER, OP_RD_REG, OP_STATUS:             return CLS_READ;
            OP_LOAD_ONE, OP_SAVE_ONE,
            OP_LOAD_ALL, OP_SAVE_ALL:                      return CLS_XFER;
            OP_STEP:                                       return CLS_STEP;
            default:                                       return CLS_BAD;
        endcase
    endfunction

    function automatic logic is_global(input logic [3:0] code);
        return (code == OP_LOAD_ALL) || (code == OP_SAVE_ALL);
    endfunction

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
    parameter int           W      = 4,
    parameter int           STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= RST_VAL;
                else     pipe[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= RST_VAL;
                else     pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_fe_pins.sv
module spi_fe_pins #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_i,
    input  logic si_i,
    input  logic csn_i,
    input  logic holdn_i,
    output logic si_s,
    output logic csn_s,
    output logic cs_fall,
    output logic held,
    output logic sck_rise_g,
    output logic sck_fall_g
);
    // bit order: {holdn, csn, si, sck}; chip select resets to the selected
    // level so a select held low through reset gives no falling edge
    localparam logic [3:0] PIN_RST = 4'b1000;

    logic [3:0] pins_s;
    logic       sck_s, holdn_s;
    logic       sck_d, csn_d;

    spi_fe_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({holdn_i, csn_i, si_i, sck_i}),
        .q   (pins_s)
    );

    assign sck_s   = pins_s[0];
    assign si_s    = pins_s[1];
    assign csn_s   = pins_s[2];
    assign holdn_s = pins_s[3];

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= 1'b0;
            csn_d <= 1'b0;
            held  <= 1'b0;
        end else begin
            sck_d <= sck_s;
            csn_d <= csn_s;
            if (csn_s)       held <= 1'b0;
            else if (!sck_s) held <= !holdn_s;
        end
    end

    assign cs_fall    = csn_d & ~csn_s;
    assign sck_rise_g = sck_s & ~sck_d & ~held;
    assign sck_fall_g = ~sck_s & sck_d & ~held;
endmodule

// File: rtl/spi_fe_seq.sv
module spi_fe_seq
    import spi_fe_pkg::*;
#(
    parameter int DATA_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csn_s,
    input  logic              cs_fall,
    input  logic              sck_rise,
    input  logic              si,
    input  logic [1:0]        dev_addr,
    output cmd_t              cmd,
    output logic              cmd_valid,
    output logic [DATA_W-1:0] data,
    output logic              step_valid,
    output logic              step_up,
    output logic              load_rd,
    output logic              out_phase
);
    seq_e              state;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] sr;
    logic [BYTE_W-1:0] sr_next;
    logic              byte_end;
    logic              id_ok;

    assign sr_next  = {sr[BYTE_W-2:0], si};
    assign byte_end = (bitcnt == CNT_W'(BYTE_W - 1));
    assign id_ok    = (sr_next[7:4] == DEV_TYPE) && (sr_next[3:2] == 2'b00)
                      && (sr_next[1:0] == dev_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            bitcnt     <= '0;
            sr         <= '0;
            cmd        <= '{op: OP_LOAD_ALL, chan: 1'b0, sel: 2'b00};
            cmd_valid  <= 1'b0;
            data       <= '0;
            step_valid <= 1'b0;
            step_up    <= 1'b0;
            load_rd    <= 1'b0;
        end else begin
            cmd_valid  <= 1'b0;
            step_valid <= 1'b0;
            load_rd    <= 1'b0;
            if (csn_s) begin
                state <= ST_IDLE;
            end else if (cs_fall) begin
                state  <= ST_ID;
                bitcnt <= '0;
            end else if (sck_rise && state != ST_IDLE) begin
                sr     <= sr_next;
                bitcnt <= byte_end ? '0 : bitcnt + 1'b1;
                case (state)
                    ST_ID: begin
                        if (byte_end) state <= id_ok ? ST_INSTR : ST_DONE;
                    end
                    ST_INSTR: begin
                        if (byte_end) begin
                            cmd.op   <= op_e'(sr_next[7:4]);
                            cmd.sel  <= sr_next[3:2];
                            cmd.chan <= is_global(sr_next[7:4]) ? 1'b0 : sr_next[0];
                            case (classify(sr_next[7:4]))
                                CLS_WRITE: state <= ST_DATA_IN;
                                CLS_READ: begin
                                    cmd_valid <= 1'b1;
                                    load_rd   <= 1'b1;
                                    state     <= ST_DATA_OUT;
                                end
                                CLS_XFER: begin
                                    cmd_valid <= 1'b1;
                                    state     <= ST_DONE;
                                end
                                CLS_STEP: state <= ST_STEP;
                                default:  state <= ST_DONE;
                            endcase
                        end
                    end
                    ST_DATA_IN: begin
                        if (byte_end) begin
                            cmd_valid <= 1'b1;
                            data      <= sr_next[DATA_W-1:0];
                            state     <= ST_DONE;
                        end
                    end
                    ST_DATA_OUT: begin
                        if (byte_end) state <= ST_DONE;
                    end
                    ST_STEP: begin
                        step_valid <= 1'b1;
                        step_up    <= si;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign out_phase = (state == ST_DATA_OUT);
endmodule

// File: rtl/spi_fe_out.sv
module spi_fe_out
    import spi_fe_pkg::*;
#(
    parameter int DATA_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csn_s,
    input  logic              load,
    input  logic              is_status,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              wip,
    input  logic              sck_fall,
    input  logic              oe_en,
    output logic              so,
    output logic              so_oe
);
    localparam int PAD_W = BYTE_W - DATA_W;

    logic [BYTE_W-1:0] sh;
    logic              so_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            so_q <= 1'b0;
        end else if (csn_s) begin
            so_q <= 1'b0;
        end else if (load) begin
            sh <= is_status ? {{(BYTE_W-1){1'b0}}, wip} : {{PAD_W{1'b0}}, rd_data};
        end else if (oe_en && sck_fall) begin
            so_q <= sh[BYTE_W-1];
            sh   <= {sh[BYTE_W-2:0], 1'b0};
        end
    end

    assign so_oe = oe_en;
    assign so    = oe_en & so_q;
endmodule

// File: rtl/spi_cmd_front.sv
module spi_cmd_front
    import spi_fe_pkg::*;
#(
    parameter int DATA_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_i,
    input  logic              si_i,
    input  logic              csn_i,
    input  logic              holdn_i,
    input  logic [1:0]        dev_addr_i,
    input  logic              wip_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              so_o,
    output logic              so_oe_o,
    output logic              cmd_valid_o,
    output logic [3:0]        cmd_op_o,
    output logic              cmd_chan_o,
    output logic [1:0]        cmd_sel_o,
    output logic [DATA_W-1:0] cmd_data_o,
    output logic              step_valid_o,
    output logic              step_up_o
);
    logic si_s, csn_s, cs_fall, held, sck_rise, sck_fall;
    logic load_rd, out_phase, oe_en;
    cmd_t cmd;

    spi_fe_pins #(.SYNC_STAGES(SYNC_STAGES)) u_pins (
        .clk        (clk),
        .rst        (rst),
        .sck_i      (sck_i),
        .si_i       (si_i),
        .csn_i      (csn_i),
        .holdn_i    (holdn_i),
        .si_s       (si_s),
        .csn_s      (csn_s),
        .cs_fall    (cs_fall),
        .held       (held),
        .sck_rise_g (sck_rise),
        .sck_fall_g (sck_fall)
    );

    spi_fe_seq #(.DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .csn_s      (csn_s),
        .cs_fall    (cs_fall),
        .sck_rise   (sck_rise),
        .si         (si_s),
        .dev_addr   (dev_addr_i),
        .cmd        (cmd),
        .cmd_valid  (cmd_valid_o),
        .data       (cmd_data_o),
        .step_valid (step_valid_o),
        .step_up    (step_up_o),
        .load_rd    (load_rd),
        .out_phase  (out_phase)
    );

    assign oe_en = out_phase & ~csn_s & ~held;

    spi_fe_out #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .csn_s     (csn_s),
        .load      (load_rd),
        .is_status (cmd.op == OP_STATUS),
        .rd_data   (rd_data_i),
        .wip       (wip_i),
        .sck_fall  (sck_fall),
        .oe_en     (oe_en),
        .so        (so_o),
        .so_oe     (so_oe_o)
    );

    assign cmd_op_o   = cmd.op;
    assign cmd_chan_o = cmd.chan;
    assign cmd_sel_o  = cmd.sel;
endmodule

// File: rtl/spi_fe_checker.sv
module spi_fe_checker (
    input logic clk,
    input logic rst,
    input logic csn_s,
    input logic held,
    input logic sck_fall,
    input logic so_o,
    input logic so_oe_o,
    input logic cmd_valid_o,
    input logic step_valid_o
);
    // R1: output disabled while deselected
    a_r1_so_off_deselected: assert property (@(posedge clk) disable iff (rst)
        csn_s |-> !so_oe_o);

    // R4: command strobe lasts one cycle
    a_r4_strobe_single: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |=> !cmd_valid_o);

    // R8: step and command strobes are exclusive
    a_r8_step_cmd_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid_o && step_valid_o));

    // R9: nothing is issued while deselected
    a_r9_no_strobe_deselected: assert property (@(posedge clk) disable iff (rst)
        (csn_s && $past(csn_s)) |-> !(cmd_valid_o || step_valid_o));

    // R10: a paused sequence is silent
    a_r10_quiet_when_held: assert property (@(posedge clk) disable iff (rst)
        (held && $past(held)) |-> !(cmd_valid_o || step_valid_o || so_oe_o));

    // R5: SO moves only after a falling serial clock edge
    a_r5_so_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
        (so_oe_o && $past(so_oe_o) && (so_o != $past(so_o))) |-> $past(sck_fall));
endmodule

bind spi_cmd_front spi_fe_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .csn_s        (csn_s),
    .held         (held),
    .sck_fall     (sck_fall),
    .so_o         (so_o),
    .so_oe_o      (so_oe_o),
    .cmd_valid_o  (cmd_valid_o),
    .step_valid_o (step_valid_o)
);

// File: tb/test_spi_cmd_front.sv
module test_spi_cmd_front;
    localparam int DW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, si = 1'b0, csn = 1'b0, holdn = 1'b1, wip = 1'b0;
    logic [1:0] dev_addr = 2'b10;
    logic [DW-1:0] rd_data;
    logic so, so_oe, cmd_valid, cmd_chan, step_valid, step_up;
    logic [3:0] cmd_op;
    logic [1:0] cmd_sel;
    logic [DW-1:0] cmd_data;

    logic [DW-1:0] bank [2][4];

    always #10 clk = ~clk;

    assign rd_data = bank[cmd_chan][cmd_sel];

    spi_cmd_front #(.DATA_W(DW)) i_spi_cmd_front (
        .clk(clk), .rst(rst), .sck_i(sck), .si_i(si), .csn_i(csn), .holdn_i(holdn),
        .dev_addr_i(dev_addr), .wip_i(wip), .rd_data_i(rd_data),
        .so_o(so), .so_oe_o(so_oe), .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op),
        .cmd_chan_o(cmd_chan), .cmd_sel_o(cmd_sel), .cmd_data_o(cmd_data),
        .step_valid_o(step_valid), .step_up_o(step_up)
    );

    typedef struct packed {
        logic          is_step;
        logic [3:0]    op;
        logic          chan;
        logic [1:0]    sel;
        logic          chk_data;
        logic [DW-1:0] data;
        logic          up;
    } exp_t;

    exp_t  exp_q [$];
    string req_q [$];
    int n_chk = 0, n_bad = 0, n_strobe = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic push_cmd(input string req, input logic [3:0] op, input logic ch,
                            input logic [1:0] sel, input bit chk, input logic [DW-1:0] d);
        exp_q.push_back('{1'b0, op, ch, sel, chk, d, 1'b0});
        req_q.push_back(req);
    endtask

    task automatic push_step(input string req, input logic ch, input logic up);
        exp_q.push_back('{1'b1, 4'h0, ch, 2'b00, 1'b0, '0, up});
        req_q.push_back(req);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && (cmd_valid || step_valid)) begin
            n_strobe++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected strobe", {cmd_valid, step_valid}, 0);
            end else begin
                exp_t e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                if (e.is_step) begin
                    check(step_valid && !cmd_valid, r, {cmd_valid, step_valid}, 1);
                    check(cmd_chan == e.chan && step_up == e.up, r,
                          {cmd_chan, step_up}, {e.chan, e.up});
                end else begin
                    check(cmd_valid && !step_valid, r, {cmd_valid, step_valid}, 2);
                    check(cmd_op == e.op && cmd_chan == e.chan && cmd_sel == e.sel, r,
                          {cmd_op, cmd_chan, cmd_sel}, {e.op, e.chan, e.sel});
                    if (e.chk_data) check(cmd_data == e.data, r, cmd_data, e.data);
                end
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one serial bit: SI set mid low phase, SO sampled just before the rise
    task automatic bit_xfer(input logic b, output logic so_s, output logic oe_s);
        wait_clk(4);
        si = b;
        wait_clk(4);
        so_s = so;
        oe_s = so_oe;
        sck = 1'b1;
        wait_clk(8);
        sck = 1'b0;
    endtask

    task automatic byte_xfer(input logic [7:0] v, output logic [7:0] got, output logic oe_all,
                             output logic oe_any);
        logic s, o;
        oe_all = 1'b1;
        oe_any = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(v[i], s, o);
            got[i] = s;
            oe_all &= o;
            oe_any |= o;
        end
    endtask

    task automatic cs_open;
        csn = 1'b0;
        wait_clk(8);
    endtask

    task automatic cs_close;
        wait_clk(6);
        csn = 1'b1;
        wait_clk(10);
    endtask

    function automatic logic [7:0] id_byte(input logic [1:0] a);
        return {4'b0101, 2'b00, a};
    endfunction

    function automatic logic [7:0] ins(input logic [3:0] op, input logic [1:0] sel, input logic ch);
        return {op, sel, 1'b0, ch};
    endfunction

    task automatic run2(input logic [7:0] b0, input logic [7:0] b1);
        logic [7:0] g;
        logic a, y;
        cs_open();
        byte_xfer(b0, g, a, y);
        byte_xfer(b1, g, a, y);
        cs_close();
    endtask

    task automatic run_write(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        logic [7:0] g;
        logic a, y;
        cs_open();
        byte_xfer(b0, g, a, y);
        byte_xfer(b1, g, a, y);
        byte_xfer(b2, g, a, y);
        cs_close();
    endtask

    task automatic run_read(input logic [7:0] b1, input logic [7:0] expv, input string req);
        logic [7:0] g;
        logic a, y;
        cs_open();
        byte_xfer(id_byte(2'b10), g, a, y);
        byte_xfer(b1, g, a, y);
        check(!y, req, y, 0);
        byte_xfer(8'h00, g, a, y);
        check(a, req, a, 1);
        check(g == expv, req, g, expv);
        cs_close();
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        wait_clk(150000);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int s0;
        logic [7:0] g;
        logic a, y, s, o;
        for (int c = 0; c < 2; c++)
            for (int r = 0; r < 4; r++)
                bank[c][r] = DW'(c * 16 + r * 5 + 3);

        wait_clk(5);
        rst = 1'b0;
        wait_clk(4);
        // reset state
        check(!cmd_valid && !step_valid && !so_oe, "R1 reset outputs",
              {cmd_valid, step_valid, so_oe}, 0);

        // R1: select held low since reset, no falling edge: command ignored
        s0 = n_strobe;
        byte_xfer(id_byte(2'b10), g, a, y);
        byte_xfer(ins(4'b1010, 2'b00, 1'b0), g, a, y);
        byte_xfer(8'h11, g, a, y);
        csn = 1'b1;
        wait_clk(12);
        check(n_strobe == s0, "R1 no fall after reset", n_strobe - s0, 0);
        check(!so_oe, "R1 so disabled when deselected", so_oe, 0);

        // R4 writes
        push_cmd("R4 write wiper", 4'b1010, 1'b1, 2'b00, 1, 6'h2A);
        run_write(id_byte(2'b10), ins(4'b1010, 2'b00, 1'b1), 8'h2A);
        push_cmd("R4 write register", 4'b1100, 1'b0, 2'b10, 1, 6'h15);
        run_write(id_byte(2'b10), ins(4'b1100, 2'b10, 1'b0), 8'h15);
        push_cmd("R3 register select field", 4'b1100, 1'b1, 2'b01, 1, 6'h3F);
        run_write(id_byte(2'b10), ins(4'b1100, 2'b01, 1'b1), 8'h3F);

        // R5 reads
        push_cmd("R5 read register strobe", 4'b1011, 1'b1, 2'b11, 0, '0);
        run_read(ins(4'b1011, 2'b11, 1'b1), {2'b00, bank[1][3]}, "R5 read register");
        push_cmd("R5 read wiper strobe", 4'b1001, 1'b0, 2'b00, 0, '0);
        run_read(ins(4'b1001, 2'b00, 1'b0), {2'b00, bank[0][0]}, "R5 read wiper");

        // R6 status
        wip = 1'b1;
        push_cmd("R6 status strobe", 4'b0101, 1'b1, 2'b00, 0, '0);
        run_read(ins(4'b0101, 2'b00, 1'b1), 8'h01, "R6 status busy");
        wip = 1'b0;
        push_cmd("R6 status strobe", 4'b0101, 1'b1, 2'b00, 0, '0);
        run_read(ins(4'b0101, 2'b00, 1'b1), 8'h00, "R6 status idle");

        // R7 transfers
        push_cmd("R7 load one", 4'b1101, 1'b1, 2'b10, 0, '0);
        run2(id_byte(2'b10), ins(4'b1101, 2'b10, 1'b1));
        push_cmd("R7 save one", 4'b1110, 1'b0, 2'b11, 0, '0);
        run2(id_byte(2'b10), ins(4'b1110, 2'b11, 1'b0));
        push_cmd("R7 load all chan 0", 4'b0001, 1'b0, 2'b01, 0, '0);
        run2(id_byte(2'b10), ins(4'b0001, 2'b01, 1'b1));
        push_cmd("R7 save all chan 0", 4'b1000, 1'b0, 2'b10, 0, '0);
        run2(id_byte(2'b10), ins(4'b1000, 2'b10, 1'b1));

        // R2 identification mismatches
        s0 = n_strobe;
        run_write(id_byte(2'b01), ins(4'b1010, 2'b00, 1'b0), 8'h05);
        run_write(8'h75, ins(4'b1010, 2'b00, 1'b0), 8'h05);
        run_write(8'h56, ins(4'b1010, 2'b00, 1'b0), 8'h05);
        check(n_strobe == s0, "R2 id mismatch ignored", n_strobe - s0, 0);
        dev_addr = 2'b01;
        push_cmd("R2 new strap address", 4'b1010, 1'b0, 2'b00, 1, 6'h09);
        run_write(id_byte(2'b01), ins(4'b1010, 2'b00, 1'b0), 8'h09);
        dev_addr = 2'b10;

        // R3 undefined opcode
        s0 = n_strobe;
        run_write(id_byte(2'b10), ins(4'b0011, 2'b00, 1'b0), 8'h07);
        run_write(id_byte(2'b10), ins(4'b1111, 2'b00, 1'b0), 8'h07);
        check(n_strobe == s0, "R3 undefined opcode ignored", n_strobe - s0, 0);

        // R8 stepping
        push_step("R8 step up", 1'b1, 1'b1);
        push_step("R8 step up", 1'b1, 1'b1);
        push_step("R8 step down", 1'b1, 1'b0);
        push_step("R8 step up", 1'b1, 1'b1);
        cs_open();
        byte_xfer(id_byte(2'b10), g, a, y);
        byte_xfer(ins(4'b0010, 2'b00, 1'b1), g, a, y);
        bit_xfer(1'b1, s, o);
        bit_xfer(1'b1, s, o);
        bit_xfer(1'b0, s, o);
        bit_xfer(1'b1, s, o);
        cs_close();

        // R9 abort mid data byte
        s0 = n_strobe;
        cs_open();
        byte_xfer(id_byte(2'b10), g, a, y);
        byte_xfer(ins(4'b1100, 2'b00, 1'b0), g, a, y);
        for (int i = 0; i < 4; i++) bit_xfer(1'b1, s, o);
        cs_close();
        check(n_strobe == s0, "R9 abort gives no strobe", n_strobe - s0, 0);

        // R10 pause in a write
        push_cmd("R10 write across pause", 4'b1010, 1'b0, 2'b00, 1, 6'h2D);
        cs_open();
        byte_xfer(id_byte(2'b10), g, a, y);
        byte_xfer(ins(4'b1010, 2'b00, 1'b0), g, a, y);
        bit_xfer(1'b0, s, o);
        bit_xfer(1'b0, s, o);
        bit_xfer(1'b1, s, o);
        holdn = 1'b0;
        wait_clk(8);
        bit_xfer(1'b1, s, o);
        bit_xfer(1'b1, s, o);
        holdn = 1'b1;
        wait_clk(8);
        for (int i = 4; i >= 0; i--) bit_xfer(1'(8'h2D >> i), s, o);
        cs_close();

        // R10 pause in a read
        push_cmd("R10 read strobe", 4'b1011, 1'b0, 2'b01, 0, '0);
        cs_open();
        byte_xfer(id_byte(2'b10), g, a, y);
        byte_xfer(ins(4'b1011, 2'b01, 1'b0), g, a, y);
        g = '0;
        bit_xfer(1'b0, s, o); g[7] = s;
        bit_xfer(1'b0, s, o); g[6] = s;
        holdn = 1'b0;
        wait_clk(8);
        check(!so_oe, "R10 so disabled while paused", so_oe, 0);
        bit_xfer(1'b0, s, o);
        holdn = 1'b1;
        wait_clk(8);
        for (int i = 5; i >= 0; i--) begin
            bit_xfer(1'b0, s, o);
            g[i] = s;
        end
        check(g == {2'b00, bank[0][1]}, "R10 read resumes at same bit", g, {2'b00, bank[0][1]});
        cs_close();

        wait_clk(10);
        check(exp_q.size() == 0, "R4 all expected strobes seen", exp_q.size(), 0);
        finish_run();
    end
endmodule